// File: doc/BRIEF.md
# Flag-Inverting Parallel-Prefix Adder/Subtractor

This block is a purely combinational n-bit adder/subtractor. A single carry computation gives it eight results. The operands pass through a bit-level generate/propagate stage and then a log-depth Kogge-Stone-style prefix network. Every node in that network forms both a group generate and a group propagate. The carries that come out of the network give a raw sum. The group propagates rooted at bit 0 form a vector of flags. Flag i marks the bits that would toggle if one were added to the raw sum. XORing the flags into the raw sum therefore gives the raw sum plus one, with no second carry chain.

Subtraction inverts the second operand and uses a carry-in of zero, so the raw sum is A-B-1. Two mode controls pick the output. One chooses between the raw and the incremented sum, and the other can complement that choice. Together they give the plain, the plus-one and the negated forms of the sum or difference. The block suits datapaths that need A+B, A+B+1, A-B, B-A and their one's-complement variants from a single adder of one delay.

Top module: `flag_prefix_adder`

## Requirements
- R1: With sub_en=0, inc_sel=0, neg_sel=0, result equals (A+B) mod 2^WIDTH.
- R2: With sub_en=0, inc_sel=1, neg_sel=0, result equals (A+B+1) mod 2^WIDTH.
- R3: With sub_en=0, inc_sel=0, neg_sel=1, result equals -(A+B+2) mod 2^WIDTH.
- R4: With sub_en=0, inc_sel=1, neg_sel=1, result equals -(A+B+1) mod 2^WIDTH.
- R5: With sub_en=1, inc_sel=0, neg_sel=0, result equals (A-B-1) mod 2^WIDTH.
- R6: With sub_en=1, inc_sel=1, neg_sel=0, result equals (A-B) mod 2^WIDTH.
- R7: With sub_en=1, inc_sel=0, neg_sel=1, result equals (B-A) mod 2^WIDTH.
- R8: With sub_en=1, inc_sel=1, neg_sel=1, result equals (B-A-1) mod 2^WIDTH.
- R9: Flag i is set exactly when every bit propagate below position i is set, and flag 0 is always set. As a result, a raw sum of all ones that is incremented wraps to zero, and the plus-one form always equals the raw sum plus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand A |
| opb | input | WIDTH | Second operand B |
| sub_en | input | 1 | 1 selects subtraction (B inverted, carry-in zero) |
| inc_sel | input | 1 | Selects the flag-incremented form (see R1 to R8) |
| neg_sel | input | 1 | Selects the complemented form (see R1 to R8) |
| result | output | WIDTH | Selected result |

## Verification
All eight control combinations are applied to each operand pair. The pairs are the extremes (zero, one, all ones, the sign bit alone) and the two alternating bit patterns, taken in every pairing, followed by a long stream of random pairs. The extreme pairs exercise the full-length carry ripple and the wrap of the incremented sum, where all flags are set together. The alternating pairs separate a propagate chain that breaks at every other bit from one that runs unbroken. The random pairs cover the ordinary mix of partial chains. A separate check forces the raw sum to all ones, so that every flag is set and the incremented result must wrap to zero.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

   // Generate/propagate pair carried through the prefix network.
   typedef struct packed {
      logic g;
      logic p;
   } gp_t;

   // Prefix combine: hi covers the more significant span, lo the less.
   function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
      gp_t r;
      r.g = hi.g | (hi.p & lo.g);
      r.p = hi.p & lo.p;
      return r;
   endfunction

endpackage

// File: rtl/fpa_precond.sv
module fpa_precond #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             sub_i,
   output logic [WIDTH-1:0] b_eff_o,
   output logic [WIDTH-2:0] g_o,
   output logic [WIDTH-1:0] p_o
);

   initial begin
      if (WIDTH < 2) $error("fpa_precond: WIDTH must be at least 2");
   end

   assign b_eff_o = sub_i ? ~b_i : b_i;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign p_o[i] = a_i[i] ^ b_eff_o[i];
      if (i < WIDTH - 1) begin : g_gen
         assign g_o[i] = a_i[i] & b_eff_o[i];
      end
   end

endmodule

// File: rtl/fpa_prefix_tree.sv
module fpa_prefix_tree
   import fpa_pkg::*;
#(
   parameter int N = 15
) (
   input  logic [N-1:0] g_i,
   input  logic [N-1:0] p_i,
   output logic [N-1:0] grp_g_o,
   output logic [N-1:0] grp_p_o
);

   localparam int LEVELS = (N > 1) ? $clog2(N) : 0;

   initial begin
      if (N < 1) $error("fpa_prefix_tree: N must be at least 1");
   end

   gp_t [N-1:0] lvl [0:LEVELS];

   for (genvar i = 0; i < N; i++) begin : g_seed
      assign lvl[0][i].g = g_i[i];
      assign lvl[0][i].p = p_i[i];
   end

   for (genvar k = 1; k <= LEVELS; k++) begin : g_level
      localparam int DIST = 1 << (k - 1);
      for (genvar i = 0; i < N; i++) begin : g_node
         if (i >= DIST) begin : g_full
            assign lvl[k][i] = gp_merge(lvl[k-1][i], lvl[k-1][i-DIST]);
         end else begin : g_buf
            assign lvl[k][i] = lvl[k-1][i];
         end
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_out
      assign grp_g_o[i] = lvl[LEVELS][i].g;
      assign grp_p_o[i] = lvl[LEVELS][i].p;
   end

endmodule

// File: rtl/fpa_post.sv
module fpa_post #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] p_i,
   input  logic [WIDTH-2:0] grp_g_i,
   input  logic [WIDTH-2:0] grp_p_i,
   output logic [WIDTH-1:0] sum_o,
   output logic [WIDTH-1:0] inc_o
);

   logic [WIDTH-1:0] carry;
   logic [WIDTH-1:0] flag;

   assign carry = {grp_g_i, 1'b0};
   assign flag  = {grp_p_i, 1'b1};
   assign sum_o = p_i ^ carry;
   assign inc_o = sum_o ^ flag;

   always_comb begin
      // R9
      flag_base_chk: assert (flag[0]);
      for (int i = 0; i < WIDTH - 1; i++) begin
         // R9
         flag_chain_chk: assert (flag[i+1] == (flag[i] & p_i[i]));
      end
      // R9
      inc_rel_chk: assert (inc_o == sum_o + 1'b1);
   end

endmodule

// File: rtl/flag_prefix_adder.sv
module flag_prefix_adder #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             sub_en,
   input  logic             inc_sel,
   input  logic             neg_sel,
   output logic [WIDTH-1:0] result
);

   initial begin
      if (WIDTH < 2) $error("flag_prefix_adder: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] b_eff;
   logic [WIDTH-2:0] g_bit;
   logic [WIDTH-1:0] p_bit;
   logic [WIDTH-2:0] grp_g;
   logic [WIDTH-2:0] grp_p;
   logic [WIDTH-1:0] sum_raw;
   logic [WIDTH-1:0] sum_inc;
   logic             use_inc;
   logic [WIDTH-1:0] picked;

   fpa_precond #(.WIDTH(WIDTH)) u_pre (
      .a_i    (opa),
      .b_i    (opb),
      .sub_i  (sub_en),
      .b_eff_o(b_eff),
      .g_o    (g_bit),
      .p_o    (p_bit)
   );

   fpa_prefix_tree #(.N(WIDTH-1)) u_tree (
      .g_i    (g_bit),
      .p_i    (p_bit[WIDTH-2:0]),
      .grp_g_o(grp_g),
      .grp_p_o(grp_p)
   );

   fpa_post #(.WIDTH(WIDTH)) u_post (
      .p_i    (p_bit),
      .grp_g_i(grp_g),
      .grp_p_i(grp_p),
      .sum_o  (sum_raw),
      .inc_o  (sum_inc)
   );

   // Negated add forms swap which sum is complemented; subtract forms do not.
   assign use_inc = inc_sel ^ (neg_sel & ~sub_en);
   assign picked  = use_inc ? sum_inc : sum_raw;
   assign result  = neg_sel ? ~picked : picked;

   always_comb begin
      // R1 R5
      raw_sum_chk: assert (sum_raw == opa + b_eff);
      // R2 R6
      sel_plain_chk: assert (neg_sel || result == sum_raw || result == sum_inc);
      // R3 R7
      sel_neg_chk: assert (!neg_sel || result == ~sum_raw || result == ~sum_inc);
   end

endmodule

// File: tb/flag_prefix_adder_tb.sv
`timescale 1ns/1ps
module flag_prefix_adder_tb_top;

   localparam int W = 16;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic [W-1:0] opa, opb;
   logic sub_en, inc_sel, neg_sel;
   logic [W-1:0] result;

   int vectors = 0;
   int fails   = 0;
   bit done    = 0;

   flag_prefix_adder #(.WIDTH(W)) dut_i (
      .opa(opa), .opb(opb), .sub_en(sub_en),
      .inc_sel(inc_sel), .neg_sel(neg_sel), .result(result)
   );

   function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                          input logic s, input logic i, input logic n);
      longint x = longint'(a);
      longint y = longint'(b);
      longint r;
      case ({s, i, n})
         3'b000: r = x + y;
         3'b010: r = x + y + 1;
         3'b001: r = -(x + y + 2);
         3'b011: r = -(x + y + 1);
         3'b100: r = x - y - 1;
         3'b110: r = x - y;
         3'b101: r = y - x;
         default: r = y - x - 1;
      endcase
      return r[W-1:0];
   endfunction

   function automatic string tag(input logic s, input logic i, input logic n);
      case ({s, i, n})
         3'b000: return "R1";
         3'b010: return "R2";
         3'b001: return "R3";
         3'b011: return "R4";
         3'b100: return "R5";
         3'b110: return "R6";
         3'b101: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic s, input logic i, input logic n, input string req);
      logic [W-1:0] exp;
      @(posedge clk);
      opa = a; opb = b; sub_en = s; inc_sel = i; neg_sel = n;
      exp = model(a, b, s, i, n);
      @(negedge clk);
      vectors++;
      if (result !== exp) begin
         fails++;
         $display("FAIL %s a=%h b=%h mode=%b%b%b actual=%h expected=%h",
                  req, a, b, s, i, n, result, exp);
      end
   endtask

   task automatic all_modes(input logic [W-1:0] a, input logic [W-1:0] b);
      for (int m = 0; m < 8; m++) begin
         apply(a, b, m[2], m[1], m[0], tag(m[2], m[1], m[0]));
      end
   endtask

   initial begin
      logic [W-1:0] corners [6];
      opa = '0; opb = '0; sub_en = 0; inc_sel = 0; neg_sel = 0;
      corners[0] = '0;
      corners[1] = {{(W-1){1'b0}}, 1'b1};
      corners[2] = '1;
      corners[3] = {1'b1, {(W-1){1'b0}}};
      for (int k = 0; k < W; k++) begin
         corners[4][k] = k[0];
         corners[5][k] = ~k[0];
      end
      repeat (2) @(posedge clk);
      // R1: initial state, all-zero inputs give zero
      apply('0, '0, 0, 0, 0, "R1");
      for (int x = 0; x < 6; x++) begin
         for (int y = 0; y < 6; y++) begin
            all_modes(corners[x], corners[y]);
         end
      end
      // R9: raw sum all ones, so every flag is set and increment wraps
      apply(corners[4], corners[5], 0, 1, 0, "R9");
      apply('1, '0, 0, 1, 0, "R9");
      apply('1, '1, 1, 1, 0, "R9");
      for (int r = 0; r < 600; r++) begin
         all_modes(W'($urandom), W'($urandom));
      end
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule